// File: doc/BRIEF.md
# Clock Output Gating Controller

This block decides, for every clock output of a clock generator, whether the output toggles, sits at a fixed driven level, or floats. It serves sixteen lanes. Lanes 0-5 are the general differential reference outputs. Lanes 6-7 are the selectable differential outputs. Lanes 8-9 are the processor differential outputs. Lanes 10-15 are the single-ended outputs, in this order: three reference outputs, the bus clock, the 48 MHz clock and the 66 MHz link clock. Enables, stop masks and drive-mode bits come in as static register values. An active-low clock-request pin and an active-high power-down pin are the run-time controls.

Each lane has its own clock input. The two pins are synchronized separately in every lane's domain. A small state machine per lane picks one of four states. `ST_RUN` toggles the output. `ST_PARK` holds it driven, with true low and complement high. `ST_FLOAT` marks it high impedance. `ST_OFF` means disabled by register: high impedance for differential lanes, driven low for single-ended lanes. Four transitions lead into these states: GO_RUN, GO_PARK, GO_FLOAT and GO_OFF. Any state can take any of them, and the state register changes only on the falling edge of the lane clock. The gated clock `lane_gclk` is the lane clock ANDed with the run state. `lane_gclk_n` is its inverse.

Top module: `clkgate_ctrl`

## Requirements
- R1: While `rst_n` is low, every lane shows `lane_run`=0, `lane_hiz`=0, `lane_gclk`=0 and `lane_gclk_n`=1.
- R2: A lane that is enabled, with `pwr_dn`=0, and not stopped by request has `lane_run`=1. Its `lane_gclk` equals its clock and `lane_gclk_n` equals the inverse of its clock.
- R3: An enable bit of 0 stops its lane whatever the pins are. A disabled differential lane (0-9) has `lane_hiz`=1.
- R4: A disabled single-ended lane (10-15) has `lane_hiz`=0 and is parked low. Single-ended lanes never assert `lane_hiz`.
- R5: When `clkreq_n`=1, a lane from 0-5 whose bit in `src_req_mask` is 1 stops. A lane from 0-5 whose mask bit is 0 keeps running. When `clkreq_n` returns to 0, the stopped lanes restart.
- R6: A lane stopped by request has `lane_hiz`=`req_stop_float`. A stopped, not floating lane has `lane_gclk`=0 and `lane_gclk_n`=1, and never has run and hiz set together.
- R7: `clkreq_n` has no effect on lanes 6-15.
- R8: When `pwr_dn`=1, every lane stops. Lanes 8-9 have `lane_hiz`=`cpu_pd_float`. Lanes 0-7 have `lane_hiz`=`src_pd_float`. Lanes 10-15 park low and driven.
- R9: A disabled lane behaves as in R3/R4 even during power-down or request stop. During power-down, the power-down mode bit decides `lane_hiz` even for a lane that is also stopped by request.
- R10: A pin change that is set up after a falling edge is captured by the next two rising edges of the lane clock. It takes effect on `lane_run`/`lane_hiz` at the falling edge that follows, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_clk | input | 16 | Per-lane source clock |
| src_en | input | 6 | Enables for lanes 0-5 |
| srcs_en | input | 2 | Enables for lanes 6-7 |
| cpu_en | input | 2 | Enables for lanes 8-9 |
| se_en | input | 6 | Enables for lanes 10-15 |
| src_req_mask | input | 6 | 1 makes lane 0-5 stoppable by request pin |
| req_stop_float | input | 1 | 1: request-stopped lanes float, 0: parked driven |
| cpu_pd_float | input | 1 | 1: lanes 8-9 float in power-down |
| src_pd_float | input | 1 | 1: lanes 0-7 float in power-down |
| clkreq_n | input | 1 | Active-low clock request pin |
| pwr_dn | input | 1 | Active-high power-down pin |
| lane_run | output | 16 | Lane toggling |
| lane_hiz | output | 16 | Lane output high impedance |
| lane_gclk | output | 16 | Gated true clock |
| lane_gclk_n | output | 16 | Gated complement clock |

## Verification
The assertions take the enable, mask and drive-mode inputs to be quasi-static register values. They assume these inputs hold steady across the falling edge that samples them, and they ignore the pins until a lane has seen several rising edges since reset. The bench changes every input one nanosecond after a falling edge. It then lets five clock periods pass before it compares. The one exception is the timing test, which samples at each edge after a pin change. All lane clocks are fed from one bench clock, so every lane shares the same sampling points.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    // Per-lane state: running, parked driven, floating, disabled by register
    typedef enum logic [1:0] {
        ST_PARK  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLOAT = 2'd2,
        ST_OFF   = 2'd3
    } lane_state_t;

    // Static per-lane controls gathered from the register side
    typedef struct packed {
        logic en;        // lane enable
        logic req_mask;  // lane may be stopped by the request pin
        logic pd_float;  // lane floats during power-down
    } lane_ctl_t;

endpackage

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clkgate_gate.sv
module clkgate_gate (
    input  logic clk,
    input  logic run,
    output logic gclk,
    output logic gclk_n
);
    // run changes only while clk is low, so neither output can glitch
    assign gclk   = clk & run;
    assign gclk_n = ~(clk & run);
endmodule

// File: rtl/clkgate_lane.sv
module clkgate_lane
    import clkgate_pkg::*;
#(
    parameter bit IS_DIFF     = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  lane_ctl_t ctl,
    input  logic      req_stop_float,
    input  logic      clkreq_n,
    input  logic      pwr_dn,
    output logic      run,
    output logic      hiz,
    output logic      gclk,
    output logic      gclk_n
);
    lane_state_t state, nxt;
    logic req_stop_s, pd_s;

    // Request pin: synchronized, reset to "stop requested"
    clkgate_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .d(clkreq_n), .q(req_stop_s)
    );

    // Power-down pin: synchronized, reset to "not powered down"
    clkgate_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pd_sync (
        .clk(clk), .rst_n(rst_n), .d(pwr_dn), .q(pd_s)
    );

    // Next state, priority: disable, then power-down, then request
    always_comb begin
        if (!ctl.en)
            nxt = ST_OFF;                                   // GO_OFF
        else if (pd_s)
            nxt = ctl.pd_float ? ST_FLOAT : ST_PARK;        // GO_FLOAT / GO_PARK
        else if (ctl.req_mask && req_stop_s)
            nxt = req_stop_float ? ST_FLOAT : ST_PARK;      // GO_FLOAT / GO_PARK
        else
            nxt = ST_RUN;                                   // GO_RUN
    end

    // State register on the falling edge: changes only while clk is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PARK;
        else        state <= nxt;
    end

    // Outputs decoded from state
    always_comb begin
        unique case (state)
            ST_RUN:   begin run = 1'b1; hiz = 1'b0;    end
            ST_PARK:  begin run = 1'b0; hiz = 1'b0;    end
            ST_FLOAT: begin run = 1'b0; hiz = IS_DIFF; end
            ST_OFF:   begin run = 1'b0; hiz = IS_DIFF; end
            default:  begin run = 1'b0; hiz = 1'b0;    end
        endcase
    end

    clkgate_gate u_gate (
        .clk(clk), .run(run), .gclk(gclk), .gclk_n(gclk_n)
    );
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
    import clkgate_pkg::*;
#(
    parameter int N_SRC       = 6,
    parameter int N_SRCS      = 2,
    parameter int N_CPU       = 2,
    parameter int N_SE        = 6,
    parameter int SYNC_STAGES = 2,
    localparam int N_DIFF     = N_SRC + N_SRCS + N_CPU,
    localparam int N_LANES    = N_DIFF + N_SE
) (
    input  logic               rst_n,
    input  logic [N_LANES-1:0] lane_clk,
    input  logic [N_SRC-1:0]   src_en,
    input  logic [N_SRCS-1:0]  srcs_en,
    input  logic [N_CPU-1:0]   cpu_en,
    input  logic [N_SE-1:0]    se_en,
    input  logic [N_SRC-1:0]   src_req_mask,
    input  logic               req_stop_float,
    input  logic               cpu_pd_float,
    input  logic               src_pd_float,
    input  logic               clkreq_n,
    input  logic               pwr_dn,
    output logic [N_LANES-1:0] lane_run,
    output logic [N_LANES-1:0] lane_hiz,
    output logic [N_LANES-1:0] lane_gclk,
    output logic [N_LANES-1:0] lane_gclk_n
);
    localparam int OFS_SRCS = N_SRC;
    localparam int OFS_CPU  = N_SRC + N_SRCS;
    localparam int OFS_SE   = N_DIFF;

    lane_ctl_t ctl [N_LANES];

    genvar g;
    for (g = 0; g < N_SRC; g++) begin : g_src_ctl
        assign ctl[g] = lane_ctl_t'{en: src_en[g], req_mask: src_req_mask[g],
                                    pd_float: src_pd_float};
    end
    for (g = 0; g < N_SRCS; g++) begin : g_srcs_ctl
        assign ctl[OFS_SRCS+g] = lane_ctl_t'{en: srcs_en[g], req_mask: 1'b0,
                                             pd_float: src_pd_float};
    end
    for (g = 0; g < N_CPU; g++) begin : g_cpu_ctl
        assign ctl[OFS_CPU+g] = lane_ctl_t'{en: cpu_en[g], req_mask: 1'b0,
                                            pd_float: cpu_pd_float};
    end
    for (g = 0; g < N_SE; g++) begin : g_se_ctl
        assign ctl[OFS_SE+g] = lane_ctl_t'{en: se_en[g], req_mask: 1'b0,
                                           pd_float: 1'b0};
    end

    for (g = 0; g < N_LANES; g++) begin : g_lane
        clkgate_lane #(
            .IS_DIFF     (g < N_DIFF),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_lane (
            .clk            (lane_clk[g]),
            .rst_n          (rst_n),
            .ctl            (ctl[g]),
            .req_stop_float (req_stop_float),
            .clkreq_n       (clkreq_n),
            .pwr_dn         (pwr_dn),
            .run            (lane_run[g]),
            .hiz            (lane_hiz[g]),
            .gclk           (lane_gclk[g]),
            .gclk_n         (lane_gclk_n[g])
        );
    end
endmodule

// File: rtl/clkgate_ctrl_chk.sv
module clkgate_ctrl_chk #(
    parameter int N_SRC  = 6,
    parameter int N_SRCS = 2,
    parameter int N_CPU  = 2,
    parameter int N_SE   = 6,
    localparam int N_DIFF  = N_SRC + N_SRCS + N_CPU,
    localparam int N_LANES = N_DIFF + N_SE
) (
    input logic               rst_n,
    input logic [N_LANES-1:0] lane_clk,
    input logic [N_SRC-1:0]   src_en,
    input logic [N_SRCS-1:0]  srcs_en,
    input logic [N_CPU-1:0]   cpu_en,
    input logic [N_SE-1:0]    se_en,
    input logic               pwr_dn,
    input logic [N_LANES-1:0] lane_run,
    input logic [N_LANES-1:0] lane_hiz,
    input logic [N_LANES-1:0] lane_gclk,
    input logic [N_LANES-1:0] lane_gclk_n
);
    logic [N_LANES-1:0] en_all;
    assign en_all = {se_en, cpu_en, srcs_en, src_en};

    genvar i;
    for (i = 0; i < N_LANES; i++) begin : g_chk
        logic [2:0] age;
        always_ff @(posedge lane_clk[i] or negedge rst_n) begin
            if (!rst_n)          age <= 3'd0;
            else if (age != 3'd4) age <= age + 3'd1;
        end

        assert_run_hiz_excl_R6: assert property (@(posedge lane_clk[i]) disable iff (!rst_n)
            !(lane_run[i] && lane_hiz[i]));

        assert_park_levels_R6: assert property (@(posedge lane_clk[i]) disable iff (!rst_n)
            !lane_run[i] |-> (!lane_gclk[i] && lane_gclk_n[i]));

        assert_run_needs_en_R3: assert property (@(posedge lane_clk[i]) disable iff (!rst_n)
            (age != 3'd0 && lane_run[i]) |-> $past(en_all[i]));

        assert_disabled_stop_R3: assert property (@(posedge lane_clk[i]) disable iff (!rst_n)
            (age >= 3'd2 && !en_all[i] && !$past(en_all[i])) |-> !lane_run[i]);

        assert_pd_stop_R8: assert property (@(posedge lane_clk[i]) disable iff (!rst_n)
            (age == 3'd4 && pwr_dn && $past(pwr_dn) && $past(pwr_dn, 2) && $past(pwr_dn, 3))
            |-> !lane_run[i]);

        if (i < N_DIFF) begin : g_diff
            assert_diff_off_float_R3: assert property (@(posedge lane_clk[i]) disable iff (!rst_n)
                (age >= 3'd2 && !en_all[i] && !$past(en_all[i])) |-> lane_hiz[i]);
        end else begin : g_se
            assert_se_driven_R4: assert property (@(posedge lane_clk[i]) disable iff (!rst_n)
                !lane_hiz[i]);
        end
    end
endmodule

bind clkgate_ctrl clkgate_ctrl_chk #(
    .N_SRC(N_SRC), .N_SRCS(N_SRCS), .N_CPU(N_CPU), .N_SE(N_SE)
) u_chk (.*);

// File: tb/sim_clkgate_ctrl.sv
module sim_clkgate_ctrl;
    localparam int N = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic         rst_n;
    logic [N-1:0] en_v;
    logic [5:0]   src_req_mask;
    logic         req_stop_float, cpu_pd_float, src_pd_float, clkreq_n, pwr_dn;
    logic [N-1:0] lane_run, lane_hiz, lane_gclk, lane_gclk_n;

    int checks = 0;
    int errors = 0;

    clkgate_ctrl u0 (
        .rst_n          (rst_n),
        .lane_clk       ({N{clk}}),
        .src_en         (en_v[5:0]),
        .srcs_en        (en_v[7:6]),
        .cpu_en         (en_v[9:8]),
        .se_en          (en_v[15:10]),
        .src_req_mask   (src_req_mask),
        .req_stop_float (req_stop_float),
        .cpu_pd_float   (cpu_pd_float),
        .src_pd_float   (src_pd_float),
        .clkreq_n       (clkreq_n),
        .pwr_dn         (pwr_dn),
        .lane_run       (lane_run),
        .lane_hiz       (lane_hiz),
        .lane_gclk      (lane_gclk),
        .lane_gclk_n    (lane_gclk_n)
    );

    task automatic chk(input string tag, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Expected run / hiz from the requirements
    function automatic void expect_vec(output logic [N-1:0] r, output logic [N-1:0] h);
        for (int i = 0; i < N; i++) begin
            bit diff = (i < 10);
            bit src  = (i < 6);
            bit cpu  = (i == 8 || i == 9);
            if (!en_v[i]) begin
                r[i] = 1'b0; h[i] = diff;
            end else if (pwr_dn) begin
                r[i] = 1'b0; h[i] = cpu ? cpu_pd_float : (diff ? src_pd_float : 1'b0);
            end else if (src && src_req_mask[i] && clkreq_n) begin
                r[i] = 1'b0; h[i] = req_stop_float;
            end else begin
                r[i] = 1'b1; h[i] = 1'b0;
            end
        end
    endfunction

    task automatic settle();
        repeat (5) @(posedge clk);
        @(negedge clk); #1;
    endtask

    // Called 1 ns after a falling edge; checks both clock phases
    task automatic check_lanes(input string tag);
        logic [N-1:0] r, h;
        expect_vec(r, h);
        chk(tag, "run", lane_run, r);
        chk(tag, "hiz", lane_hiz, h);
        chk(tag, "gclk_low_phase", lane_gclk, '0);
        chk(tag, "gclk_n_low_phase", lane_gclk_n, '1);
        @(posedge clk); #1;
        chk(tag, "gclk_high_phase", lane_gclk, r);
        chk(tag, "gclk_n_high_phase", lane_gclk_n, ~r);
        @(negedge clk); #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        en_v = '1; src_req_mask = '0; req_stop_float = 1'b1;
        cpu_pd_float = 1'b0; src_pd_float = 1'b1; clkreq_n = 1'b0; pwr_dn = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R1", "run", lane_run, '0);
        chk("R1", "hiz", lane_hiz, '0);
        chk("R1", "gclk_n", lane_gclk_n, '1);
        @(posedge clk); #1;
        chk("R1", "gclk_high_phase", lane_gclk, '0);
        chk("R1", "gclk_n_high_phase", lane_gclk_n, '1);
        @(negedge clk); #1;
        rst_n = 1'b1;
    endtask

    task automatic t_all_run();
        en_v = '1; src_req_mask = '0; clkreq_n = 1'b1; pwr_dn = 1'b0;
        settle();
        check_lanes("R2");
    endtask

    task automatic t_disable();
        en_v = 16'hA5C3;
        settle();
        check_lanes("R3");
        en_v = 16'h03FF;   // all single-ended lanes off
        settle();
        check_lanes("R4");
        en_v = '1;
    endtask

    task automatic t_request();
        en_v = '1; src_req_mask = 6'b101001; req_stop_float = 1'b1; clkreq_n = 1'b1;
        settle();
        check_lanes("R5");
        req_stop_float = 1'b0;
        settle();
        check_lanes("R6");
        clkreq_n = 1'b0;
        settle();
        check_lanes("R5");
        src_req_mask = '1; clkreq_n = 1'b1; req_stop_float = 1'b1;
        settle();
        check_lanes("R7");
        chk("R7", "lanes6_15_run", lane_run & 16'hFFC0, 16'hFFC0);
        clkreq_n = 1'b0; src_req_mask = '0;
    endtask

    task automatic t_powerdown();
        pwr_dn = 1'b1; cpu_pd_float = 1'b0; src_pd_float = 1'b1;
        settle();
        check_lanes("R8");
        cpu_pd_float = 1'b1; src_pd_float = 1'b0;
        settle();
        check_lanes("R8");
        pwr_dn = 1'b0;
        settle();
        check_lanes("R2");
    endtask

    task automatic t_priority();
        en_v = 16'b1101_1101_1111_1110;   // lanes 0, 9 and 13 disabled
        pwr_dn = 1'b1; clkreq_n = 1'b1; src_req_mask = '1;
        req_stop_float = 1'b1; src_pd_float = 1'b0; cpu_pd_float = 1'b1;
        settle();
        check_lanes("R9");
        chk("R9", "pd_mode_over_req_lane1", {15'd0, lane_hiz[1]}, 16'd0);
        pwr_dn = 1'b0; clkreq_n = 1'b0; src_req_mask = '0; en_v = '1;
        settle();
    endtask

    task automatic t_latency();
        en_v = '1; src_req_mask = 6'b000001; req_stop_float = 1'b1; clkreq_n = 1'b0;
        settle();
        chk("R10", "start_running", lane_run, '1);
        clkreq_n = 1'b1;                 // set 1 ns after a falling edge
        @(posedge clk); #1;
        chk("R10", "after_first_rise", lane_run, '1);
        @(posedge clk); #1;
        chk("R10", "after_second_rise", lane_run, '1);
        @(negedge clk); #1;
        chk("R10", "after_falling_edge", lane_run, 16'hFFFE);
        chk("R10", "hiz_after_falling_edge", lane_hiz, 16'h0001);
        clkreq_n = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        chk("R10", "restart_not_early", lane_run, 16'hFFFE);
        @(negedge clk); #1;
        chk("R10", "restart", lane_run, '1);
        src_req_mask = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_all_run();
        t_disable();
        t_request();
        t_powerdown();
        t_priority();
        t_latency();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule